// File: doc/BRIEF.md
# Secondary Cache Tag Control Unit

This unit sits between a processor bus-cycle decoder and a direct-mapped secondary cache tag array. For every processor read or write it looks up the entry selected by the low address bits. It reports a hit or a miss, and it updates the entry's valid, modified and tag fields. When a modified line has to leave the cache, it raises a write-back request that carries the old tag and the index. It also produces a cacheability indication for the processor and a next-address enable for pipelined cycles.

A seven-bit control register selects the behaviour. A fill-enable bit and a force-miss bit together give four modes: cache off; cache off with each read invalidating its entry; normal operation; and forced miss, where no access hits. In forced-miss mode, software flushes the cache by reading every index. Each read that finds a modified line emits a write-back. The SRAM type field of the register is preset from two active-low strap pins while reset is held. Cycle addresses are line addresses: the low `IDXW` bits are the index and the upper `TAGW` bits are the tag.

Top module: `l2_tag_ctrl`

## Requirements
- R1: While reset is held, the register reads back with bits [4:3] (SRAM type) equal to the inverse of `strap_pins`, and with every other bit 0. The layout is bit0 fill enable, bit1 force miss, bit2 next-address off, bits[4:3] SRAM type (00 one pipelined bank, 11 two banks, 01/10 reserved), and bits[6:5] cache size (00 means no cache).
- R2: A register write with `cfg_we` high replaces all seven bits, the strap-loaded type included. The new value is visible on `cfg_q` one clock later.
- R3: `na_o`, registered one clock after `cyc_start`, is 1 only when next-address off is 0, the size is nonzero, and the type is 00 or 11.
- R4: `ken_o`, registered one clock after `cyc_start`, equals fill enable AND `cyc_cacheable`.
- R5: `hit_o` is 1 one clock after `cyc_start` only if the entry is valid, the stored tag equals the address tag, fill enable is 1, force miss is 0, and the size is nonzero.
- R6: In normal mode, a cacheable read miss allocates its entry: valid is set, modified is cleared, and the tag is stored. Non-cacheable reads and write misses leave the entry unchanged.
- R7: An allocation that replaces a valid, modified entry raises `wb_req` in the same response cycle, with `wb_tag` and `wb_idx` set to the evicted line.
- R8: A write hit in normal mode sets the modified bit. A later eviction of that line then writes it back.
- R9: With fill enable 0 and force miss 0, reads and writes leave the tags untouched.
- R10: With fill enable 0 and force miss 1, every read clears the valid bit of its entry. Writes have no effect.
- R11: With fill enable 1 and force miss 1, no access hits and writes change nothing. A read of a valid, modified entry raises `wb_req` and clears modified while keeping the line valid.
- R12: With the size field 00, no access hits and no entry changes.
- R13: Reset clears all valid and modified bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pins | input | 2 | Active-low SRAM type straps, sampled during reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write value |
| cfg_q | output | 7 | Control register contents |
| cyc_start | input | 1 | Processor cycle start strobe |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_cacheable | input | 1 | Address falls in cacheable memory |
| cyc_addr | input | TAGW+IDXW | Line address {tag, index} |
| rsp_vld | output | 1 | Lookup response valid |
| hit_o | output | 1 | Registered hit |
| ken_o | output | 1 | Registered cacheability indication |
| na_o | output | 1 | Registered next-address enable |
| wb_req | output | 1 | Write-back request |
| wb_tag | output | TAGW | Tag of line to write back |
| wb_idx | output | IDXW | Index of line to write back |

## Verification
A normal read miss can evict a modified line and allocate the new one in the same clock edge. The write-back request must then carry the old tag, while the array already holds the new one. The bench provokes this by writing to a line and then reading a different tag at the same index. It judges the response by the write-back tag. It then re-reads the new tag and expects a hit with no further write-back. The forced-miss flush read uses the same write-back path together with a clear of the modified bit. The bench checks it by reading the same index twice and expecting one write-back only.

// File: rtl/l2tc_pkg.sv
package l2tc_pkg;
   localparam int CFG_W = 7;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_NORMAL = 2'b01,
      MODE_INVAL  = 2'b10,
      MODE_FORCED = 2'b11
   } l2tc_mode_e;

   typedef struct packed {
      logic [1:0] size;
      logic [1:0] sram_type;
      logic       na_off;
      logic       force_miss;
      logic       fill_en;
   } l2tc_cfg_t;
endpackage

// File: rtl/l2tc_cfg_reg.sv
module l2tc_cfg_reg
   import l2tc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       strap_pins,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output l2tc_cfg_t        cfg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg           <= '0;
         cfg.sram_type <= ~strap_pins;
      end else if (cfg_we) begin
         cfg <= l2tc_cfg_t'(cfg_wdata);
      end
   end

   p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg == l2tc_cfg_t'($past(cfg_wdata))));
endmodule

// File: rtl/l2tc_tag_store.sv
module l2tc_tag_store #(
   parameter int TAGW = 6,
   parameter int IDXW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] rd_idx,
   output logic            rd_valid,
   output logic            rd_mod,
   output logic [TAGW-1:0] rd_tag,
   input  logic            upd_en,
   input  logic [IDXW-1:0] upd_idx,
   input  logic            upd_valid,
   input  logic            upd_mod,
   input  logic            upd_tag_we,
   input  logic [TAGW-1:0] upd_tag
);
   localparam int DEPTH = 1 << IDXW;

   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] mod_q;
   logic [TAGW-1:0]  tag_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = upd_en && (upd_idx == IDXW'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            mod_q[e]   <= 1'b0;
            tag_q[e]   <= '0;
         end else if (sel) begin
            valid_q[e] <= upd_valid;
            mod_q[e]   <= upd_mod;
            if (upd_tag_we) tag_q[e] <= upd_tag;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_mod   = mod_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   p_upd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (valid_q[$past(upd_idx)] == $past(upd_valid)));
   p_mod_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> !(mod_q[$past(upd_idx)] && !valid_q[$past(upd_idx)]));
endmodule

// File: rtl/l2tc_lookup.sv
module l2tc_lookup
   import l2tc_pkg::*;
#(
   parameter int TAGW = 6
) (
   input  l2tc_cfg_t       cfg,
   input  logic            is_write,
   input  logic            cacheable,
   input  logic [TAGW-1:0] addr_tag,
   input  logic            e_valid,
   input  logic            e_mod,
   input  logic [TAGW-1:0] e_tag,
   output logic            hit_c,
   output logic            upd_c,
   output logic            upd_valid,
   output logic            upd_mod,
   output logic            upd_tag_we,
   output logic            wb_c
);
   l2tc_mode_e mode;
   logic       present;
   logic       match;

   assign mode    = l2tc_mode_e'({cfg.force_miss, cfg.fill_en});
   assign present = (cfg.size != 2'b00);
   assign match   = e_valid && (e_tag == addr_tag);

   always_comb begin
      hit_c      = 1'b0;
      upd_c      = 1'b0;
      upd_valid  = e_valid;
      upd_mod    = e_mod;
      upd_tag_we = 1'b0;
      wb_c       = 1'b0;
      if (present) begin
         unique case (mode)
            MODE_NORMAL: begin
               hit_c = match;
               if (is_write && match) begin
                  upd_c   = 1'b1;
                  upd_mod = 1'b1;
               end else if (!is_write && !match && cacheable) begin
                  upd_c      = 1'b1;
                  upd_valid  = 1'b1;
                  upd_mod    = 1'b0;
                  upd_tag_we = 1'b1;
                  wb_c       = e_valid && e_mod;
               end
            end
            MODE_INVAL: begin
               if (!is_write) begin
                  upd_c     = 1'b1;
                  upd_valid = 1'b0;
                  upd_mod   = 1'b0;
               end
            end
            MODE_FORCED: begin
               if (!is_write && e_valid && e_mod) begin
                  upd_c   = 1'b1;
                  upd_mod = 1'b0;
                  wb_c    = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
   import l2tc_pkg::*;
#(
   parameter int TAGW = 6,
   parameter int IDXW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           strap_pins,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_q,
   input  logic                 cyc_start,
   input  logic                 cyc_write,
   input  logic                 cyc_cacheable,
   input  logic [TAGW+IDXW-1:0] cyc_addr,
   output logic                 rsp_vld,
   output logic                 hit_o,
   output logic                 ken_o,
   output logic                 na_o,
   output logic                 wb_req,
   output logic [TAGW-1:0]      wb_tag,
   output logic [IDXW-1:0]      wb_idx
);
   localparam int AW = TAGW + IDXW;

   if (TAGW < 1 || TAGW > 32) begin : g_bad_tagw
      $error("l2_tag_ctrl: TAGW out of range");
   end
   if (IDXW < 1 || IDXW > 10) begin : g_bad_idxw
      $error("l2_tag_ctrl: IDXW out of range");
   end

   l2tc_cfg_t       cfg;
   logic [IDXW-1:0] a_idx;
   logic [TAGW-1:0] a_tag;
   logic            e_valid, e_mod;
   logic [TAGW-1:0] e_tag;
   logic            hit_c, upd_c, upd_valid, upd_mod, upd_tag_we, wb_c;
   logic            na_ok_type;

   assign a_idx = cyc_addr[IDXW-1:0];
   assign a_tag = cyc_addr[AW-1:IDXW];
   assign cfg_q = cfg;

   l2tc_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg(cfg)
   );

   l2tc_tag_store #(.TAGW(TAGW), .IDXW(IDXW)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(a_idx),
      .rd_valid(e_valid), .rd_mod(e_mod), .rd_tag(e_tag),
      .upd_en(cyc_start && upd_c), .upd_idx(a_idx),
      .upd_valid(upd_valid), .upd_mod(upd_mod),
      .upd_tag_we(upd_tag_we), .upd_tag(a_tag)
   );

   l2tc_lookup #(.TAGW(TAGW)) u_look (
      .cfg(cfg), .is_write(cyc_write), .cacheable(cyc_cacheable),
      .addr_tag(a_tag), .e_valid(e_valid), .e_mod(e_mod), .e_tag(e_tag),
      .hit_c(hit_c), .upd_c(upd_c), .upd_valid(upd_valid),
      .upd_mod(upd_mod), .upd_tag_we(upd_tag_we), .wb_c(wb_c)
   );

   assign na_ok_type = (cfg.sram_type == 2'b00) || (cfg.sram_type == 2'b11);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld <= 1'b0;
         hit_o   <= 1'b0;
         ken_o   <= 1'b0;
         na_o    <= 1'b0;
         wb_req  <= 1'b0;
         wb_tag  <= '0;
         wb_idx  <= '0;
      end else begin
         rsp_vld <= cyc_start;
         hit_o   <= cyc_start && hit_c;
         ken_o   <= cyc_start && cfg.fill_en && cyc_cacheable;
         na_o    <= cyc_start && !cfg.na_off && (cfg.size != 2'b00) && na_ok_type;
         wb_req  <= cyc_start && wb_c;
         if (cyc_start && wb_c) begin
            wb_tag <= e_tag;
            wb_idx <= a_idx;
         end
      end
   end

   p_ken_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !cfg.fill_en) |=> !ken_o);
   p_na_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && cfg.na_off) |=> !na_o);
   p_forced_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && cfg.force_miss) |=> !hit_o);
   p_nosize_nohit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && cfg.size == 2'b00) |=> !hit_o);
   p_wb_needs_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !(e_valid && e_mod)) |=> !wb_req);
   p_hit_in_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> rsp_vld);
endmodule

// File: tb/sim_l2_tag_ctrl.sv
module sim_l2_tag_ctrl;
   localparam int TAGW = 6;
   localparam int IDXW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] strap_pins = 2'b01;
   logic cfg_we = 1'b0;
   logic [6:0] cfg_wdata = '0;
   logic [6:0] cfg_q;
   logic cyc_start = 1'b0, cyc_write = 1'b0, cyc_cacheable = 1'b0;
   logic [TAGW+IDXW-1:0] cyc_addr = '0;
   logic rsp_vld, hit_o, ken_o, na_o, wb_req;
   logic [TAGW-1:0] wb_tag;
   logic [IDXW-1:0] wb_idx;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   l2_tag_ctrl #(.TAGW(TAGW), .IDXW(IDXW)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .cyc_start(cyc_start), .cyc_write(cyc_write),
      .cyc_cacheable(cyc_cacheable), .cyc_addr(cyc_addr),
      .rsp_vld(rsp_vld), .hit_o(hit_o), .ken_o(ken_o), .na_o(na_o),
      .wb_req(wb_req), .wb_tag(wb_tag), .wb_idx(wb_idx)
   );

   // {wr, cacheable, idx[4], tag[6], exp_hit, exp_wb, exp_wb_tag[6]} in normal mode
   localparam logic [19:0] VEC [12] = '{
      {1'b0, 1'b1, 4'd1, 6'd5,  1'b0, 1'b0, 6'd0},  // R6 alloc
      {1'b0, 1'b1, 4'd1, 6'd5,  1'b1, 1'b0, 6'd0},  // R5 hit
      {1'b1, 1'b1, 4'd1, 6'd5,  1'b1, 1'b0, 6'd0},  // R8 write hit
      {1'b0, 1'b1, 4'd1, 6'd9,  1'b0, 1'b1, 6'd5},  // R7 evict modified
      {1'b0, 1'b1, 4'd1, 6'd9,  1'b1, 1'b0, 6'd0},  // R6 new tag hits
      {1'b0, 1'b0, 4'd2, 6'd3,  1'b0, 1'b0, 6'd0},  // R6 noncacheable
      {1'b0, 1'b1, 4'd2, 6'd3,  1'b0, 1'b0, 6'd0},  // R6 alloc
      {1'b1, 1'b1, 4'd3, 6'd7,  1'b0, 1'b0, 6'd0},  // R6 write miss
      {1'b0, 1'b1, 4'd3, 6'd7,  1'b0, 1'b0, 6'd0},  // R6 still miss
      {1'b1, 1'b1, 4'd2, 6'd3,  1'b1, 1'b0, 6'd0},  // R8
      {1'b1, 1'b1, 4'd2, 6'd4,  1'b0, 1'b0, 6'd0},  // R6 write miss
      {1'b0, 1'b1, 4'd2, 6'd3,  1'b1, 1'b0, 6'd0}   // R6 unchanged
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [6:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_cyc(input logic wr, input logic cach, input logic [3:0] idx,
                          input logic [5:0] tag);
      @(negedge clk);
      cyc_start = 1'b1; cyc_write = wr; cyc_cacheable = cach; cyc_addr = {tag, idx};
      @(negedge clk);
      cyc_start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 strap load", 32'(cfg_q), 32'h10);
      chk("R13 reset hit", 32'(hit_o), 0);
      chk("R13 reset wb", 32'(wb_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 held after reset", 32'(cfg_q), 32'h10);
      wr_cfg(7'h21);
      chk("R2 write overrides strap", 32'(cfg_q), 32'h21);

      for (int i = 0; i < 12; i++) begin
         run_cyc(VEC[i][19], VEC[i][18], VEC[i][17:14], VEC[i][13:8]);
         chk("R5 rsp valid", 32'(rsp_vld), 1);
         chk("R5 R6 R8 vector hit", 32'(hit_o), 32'(VEC[i][7]));
         chk("R7 vector wb", 32'(wb_req), 32'(VEC[i][6]));
         if (VEC[i][6]) begin
            chk("R7 wb tag", 32'(wb_tag), 32'(VEC[i][5:0]));
            chk("R7 wb idx", 32'(wb_idx), 32'(VEC[i][17:14]));
         end
         chk("R4 ken normal", 32'(ken_o), 32'(VEC[i][18]));
         chk("R3 na normal", 32'(na_o), 1);
      end

      // R3 next-address gating
      wr_cfg(7'h25);
      run_cyc(1'b0, 1'b1, 4'd3, 6'd7);
      chk("R3 na off", 32'(na_o), 0);
      chk("R5 hit with na off", 32'(hit_o), 1);
      wr_cfg(7'h29);
      run_cyc(1'b0, 1'b1, 4'd3, 6'd7);
      chk("R3 reserved type", 32'(na_o), 0);
      wr_cfg(7'h39);
      run_cyc(1'b0, 1'b1, 4'd3, 6'd7);
      chk("R3 two banks", 32'(na_o), 1);

      // R9 off mode
      wr_cfg(7'h20);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R9 off no hit", 32'(hit_o), 0);
      chk("R4 ken off", 32'(ken_o), 0);
      run_cyc(1'b1, 1'b1, 4'd3, 6'd7);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd12);
      wr_cfg(7'h21);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R9 tags untouched", 32'(hit_o), 1);

      // R11 forced miss and flush
      wr_cfg(7'h23);
      run_cyc(1'b0, 1'b1, 4'd2, 6'd3);
      chk("R11 forced no hit", 32'(hit_o), 0);
      chk("R11 flush wb", 32'(wb_req), 1);
      chk("R11 flush wb tag", 32'(wb_tag), 3);
      chk("R11 flush wb idx", 32'(wb_idx), 2);
      run_cyc(1'b0, 1'b1, 4'd2, 6'd3);
      chk("R11 modified cleared", 32'(wb_req), 0);
      run_cyc(1'b1, 1'b1, 4'd1, 6'd9);
      chk("R11 write no hit", 32'(hit_o), 0);
      chk("R4 ken forced", 32'(ken_o), 1);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R11 write did not set modified", 32'(wb_req), 0);
      wr_cfg(7'h21);
      run_cyc(1'b0, 1'b1, 4'd2, 6'd3);
      chk("R11 line stays valid", 32'(hit_o), 1);
      chk("R11 no second wb", 32'(wb_req), 0);

      // R12 no cache size
      wr_cfg(7'h01);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R12 no hit size0", 32'(hit_o), 0);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd12);
      wr_cfg(7'h21);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R12 no alloc size0", 32'(hit_o), 1);

      // R10 invalidate on read
      wr_cfg(7'h22);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R10 no hit", 32'(hit_o), 0);
      run_cyc(1'b1, 1'b1, 4'd3, 6'd7);
      wr_cfg(7'h21);
      run_cyc(1'b0, 1'b1, 4'd1, 6'd9);
      chk("R10 read invalidated", 32'(hit_o), 0);
      chk("R10 no wb", 32'(wb_req), 0);
      run_cyc(1'b0, 1'b1, 4'd3, 6'd7);
      chk("R10 write ignored", 32'(hit_o), 1);

      // R13 reset clears entries
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wr_cfg(7'h21);
      run_cyc(1'b0, 1'b1, 4'd3, 6'd7);
      chk("R13 cleared by reset", 32'(hit_o), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule